// File: doc/BRIEF.md
# VBI Copy-Protection Pulse Detector

This block watches digitized video during a programmable band of lines in the vertical blanking interval and looks for the extra pulses that copy-protected sources insert there. One class is a burst of high-amplitude pulses meant to disturb gain control. The other is a set of dips below blanking level that imitate sync. The front-end timing supplies each sample together with its line number and its position within the line. The block qualifies runs of samples against a high and a low threshold and counts qualifying pulses of each class over the field.

When the timing signals a field boundary, the per-field counts are latched into a status word and the live counters restart. The amplitude of the gain-control pulses changes from field to field, so a pulse is judged by the threshold crossing and its duration, not by its height. A sticky `detected` flag adds hysteresis: it sets after a programmable number of consecutive fields in which both counts reach their minimums. It clears after the same number of consecutive fields that fail.

Top module: `vbi_pulse_scan`

## Requirements
- R1: After reset, `stat_agc` and `stat_psy` are zero, `stat_valid` is low and `detected` is low.
- R2: Only samples whose `line_num` lies between `cfg_start_line` and `cfg_stop_line`, both inclusive, are examined. When `cfg_stop_line` is below `cfg_start_line`, nothing is counted in any line.
- R3: A high pulse is counted once, on the valid sample that brings a run of consecutive valid in-window samples strictly above `cfg_hi_thr` to `cfg_min_width` samples. A `cfg_min_width` of 0 acts as 1. Shorter runs are not counted.
- R4: A low pulse is counted the same way for samples strictly below `cfg_lo_thr`. Only samples with `line_pos` >= `cfg_sync_guard` take part, so the real sync at the start of the line is never counted.
- R5: On a cycle with `field_done` high, the live counts move to `stat_agc`/`stat_psy` at that clock edge and the live counts restart at zero. `stat_valid` is high for exactly the one following cycle.
- R6: Each per-field count saturates at its all-ones value (63 with the default 6-bit width).
- R7: A field qualifies when its high count is >= `cfg_agc_min` and its low count is >= `cfg_psy_min`. `detected` rises after `cfg_fields` consecutive qualifying fields. A `cfg_fields` of 0 acts as 1.
- R8: Once set, `detected` falls after `cfg_fields` consecutive non-qualifying fields. A qualifying field restarts that count.
- R9: `stat_agc`, `stat_psy` and `detected` change only in the cycle that follows a `field_done` cycle.
- R10: A cycle with `smp_valid` low neither extends nor breaks a run. A valid sample that fails the comparison, or falls outside the window or guard, ends the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | SMP_W | Video sample |
| line_num | input | LINE_W | Current line number |
| line_pos | input | POS_W | Sample position within the line |
| field_done | input | 1 | One-cycle field boundary strobe |
| cfg_start_line | input | LINE_W | First examined line |
| cfg_stop_line | input | LINE_W | Last examined line |
| cfg_hi_thr | input | SMP_W | High pulse threshold |
| cfg_lo_thr | input | SMP_W | Low pulse threshold |
| cfg_min_width | input | WID_W | Minimum run length in samples |
| cfg_sync_guard | input | POS_W | First position eligible for low pulses |
| cfg_agc_min | input | CNT_W | High count needed for a qualifying field |
| cfg_psy_min | input | CNT_W | Low count needed for a qualifying field |
| cfg_fields | input | FLD_W | Consecutive fields needed to set or clear `detected` |
| stat_agc | output | CNT_W | Latched high pulse count of the last field |
| stat_psy | output | CNT_W | Latched low pulse count of the last field |
| stat_valid | output | 1 | Status word updated in the previous cycle |
| detected | output | 1 | Protection pattern present |

## Verification
A wrong run length or a wrong comparison polarity stays hidden inside a line. It surfaces only as a wrong count in the status word, one cycle after the next field boundary. A live counter that fails to restart shows up as inflated counts at the following boundary. A wrong streak count in the hysteresis logic shows up as `detected` moving one field too early or too late, so the field sequences are chosen to land on each transition exactly.

// File: rtl/vbi_scan_pkg.sv
package vbi_scan_pkg;

   typedef enum logic {
      RUN_ABOVE = 1'b0,
      RUN_BELOW = 1'b1
   } run_pol_e;

endpackage

// File: rtl/vbi_run_qual.sv
module vbi_run_qual #(
   parameter int unsigned SMP_W = 10,
   parameter int unsigned WID_W = 4,
   parameter vbi_scan_pkg::run_pol_e POL = vbi_scan_pkg::RUN_ABOVE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   input  logic [SMP_W-1:0] thr,
   input  logic [WID_W-1:0] min_width,
   input  logic             enable,
   output logic             hit
);
   localparam logic [WID_W-1:0] RUN_MAX = {WID_W{1'b1}};

   logic [WID_W-1:0] run_len;
   logic [WID_W-1:0] need;
   logic             beyond;

   generate
      if (POL == vbi_scan_pkg::RUN_ABOVE) begin : g_above
         assign beyond = smp_data > thr;
      end else begin : g_below
         assign beyond = smp_data < thr;
      end
   endgenerate

   assign need = (min_width == '0) ? WID_W'(1) : min_width;
   assign hit  = smp_valid && enable && beyond &&
                 (({1'b0, run_len} + 1'b1) == {1'b0, need});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_len <= '0;
      end else if (smp_valid) begin
         if (enable && beyond) begin
            if (run_len != RUN_MAX) run_len <= run_len + 1'b1;
         end else begin
            run_len <= '0;
         end
      end
   end
endmodule

// File: rtl/vbi_field_tally.sv
module vbi_field_tally #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic             field_done,
   output logic [CNT_W-1:0] live,
   output logic [CNT_W-1:0] latched
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live    <= '0;
         latched <= '0;
      end else if (field_done) begin
         latched <= live;
         live    <= '0;
      end else if (hit && live != CNT_MAX) begin
         live <= live + 1'b1;
      end
   end
endmodule

// File: rtl/vbi_persist.sv
module vbi_persist #(
   parameter int unsigned FLD_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             field_done,
   input  logic             qual,
   input  logic [FLD_W-1:0] fields,
   output logic             detected
);
   logic [FLD_W-1:0] streak;
   logic [FLD_W-1:0] need;
   logic             reached;

   assign need    = (fields == '0) ? FLD_W'(1) : fields;
   assign reached = ({1'b0, streak} + 1'b1) >= {1'b0, need};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         streak   <= '0;
         detected <= 1'b0;
      end else if (field_done) begin
         if (qual == detected) begin
            streak <= '0;
         end else if (reached) begin
            streak   <= '0;
            detected <= qual;
         end else begin
            streak <= streak + 1'b1;
         end
      end
   end
endmodule

// File: rtl/vbi_pulse_scan.sv
module vbi_pulse_scan #(
   parameter int unsigned SMP_W  = 10,
   parameter int unsigned LINE_W = 10,
   parameter int unsigned POS_W  = 12,
   parameter int unsigned WID_W  = 4,
   parameter int unsigned CNT_W  = 6,
   parameter int unsigned FLD_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [SMP_W-1:0]  smp_data,
   input  logic [LINE_W-1:0] line_num,
   input  logic [POS_W-1:0]  line_pos,
   input  logic              field_done,
   input  logic [LINE_W-1:0] cfg_start_line,
   input  logic [LINE_W-1:0] cfg_stop_line,
   input  logic [SMP_W-1:0]  cfg_hi_thr,
   input  logic [SMP_W-1:0]  cfg_lo_thr,
   input  logic [WID_W-1:0]  cfg_min_width,
   input  logic [POS_W-1:0]  cfg_sync_guard,
   input  logic [CNT_W-1:0]  cfg_agc_min,
   input  logic [CNT_W-1:0]  cfg_psy_min,
   input  logic [FLD_W-1:0]  cfg_fields,
   output logic [CNT_W-1:0]  stat_agc,
   output logic [CNT_W-1:0]  stat_psy,
   output logic              stat_valid,
   output logic              detected
);
   generate
      if (SMP_W < 2)  begin : g_bad_smp  $error("SMP_W must be at least 2"); end
      if (LINE_W < 4) begin : g_bad_line $error("LINE_W must be at least 4"); end
      if (WID_W < 1)  begin : g_bad_wid  $error("WID_W must be at least 1"); end
      if (CNT_W < 2)  begin : g_bad_cnt  $error("CNT_W must be at least 2"); end
      if (FLD_W < 1)  begin : g_bad_fld  $error("FLD_W must be at least 1"); end
   endgenerate

   logic             in_window;
   logic             past_guard;
   logic             agc_hit;
   logic             psy_hit;
   logic [CNT_W-1:0] agc_live;
   logic [CNT_W-1:0] psy_live;
   logic             field_qual;

   assign in_window  = (cfg_stop_line >= cfg_start_line) &&
                       (line_num >= cfg_start_line) && (line_num <= cfg_stop_line);
   assign past_guard = line_pos >= cfg_sync_guard;

   vbi_run_qual #(.SMP_W(SMP_W), .WID_W(WID_W), .POL(vbi_scan_pkg::RUN_ABOVE)) u_agc_run (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .thr(cfg_hi_thr), .min_width(cfg_min_width), .enable(in_window), .hit(agc_hit)
   );

   vbi_run_qual #(.SMP_W(SMP_W), .WID_W(WID_W), .POL(vbi_scan_pkg::RUN_BELOW)) u_psy_run (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .thr(cfg_lo_thr), .min_width(cfg_min_width), .enable(in_window && past_guard),
      .hit(psy_hit)
   );

   vbi_field_tally #(.CNT_W(CNT_W)) u_agc_tally (
      .clk(clk), .rst_n(rst_n), .hit(agc_hit), .field_done(field_done),
      .live(agc_live), .latched(stat_agc)
   );

   vbi_field_tally #(.CNT_W(CNT_W)) u_psy_tally (
      .clk(clk), .rst_n(rst_n), .hit(psy_hit), .field_done(field_done),
      .live(psy_live), .latched(stat_psy)
   );

   assign field_qual = (agc_live >= cfg_agc_min) && (psy_live >= cfg_psy_min);

   vbi_persist #(.FLD_W(FLD_W)) u_persist (
      .clk(clk), .rst_n(rst_n), .field_done(field_done), .qual(field_qual),
      .fields(cfg_fields), .detected(detected)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) stat_valid <= 1'b0;
      else        stat_valid <= field_done;
   end
endmodule

// File: rtl/vbi_scan_chk.sv
module vbi_scan_chk #(
   parameter int unsigned CNT_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             field_done,
   input logic             stat_valid,
   input logic             detected,
   input logic [CNT_W-1:0] stat_agc,
   input logic [CNT_W-1:0] stat_psy,
   input logic [CNT_W-1:0] agc_live,
   input logic [CNT_W-1:0] psy_live
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   assert_stat_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      field_done |=> stat_valid);
   assert_stat_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !field_done |=> !stat_valid);
   assert_live_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      field_done |=> (agc_live == '0) && (psy_live == '0));
   assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (agc_live == CNT_MAX) && !field_done |=> agc_live == CNT_MAX);
   assert_stat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !field_done |=> $stable(stat_agc) && $stable(stat_psy));
   assert_det_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !field_done |=> $stable(detected));
endmodule

bind vbi_pulse_scan vbi_scan_chk #(.CNT_W(CNT_W)) u_scan_chk (
   .clk(clk), .rst_n(rst_n), .field_done(field_done), .stat_valid(stat_valid),
   .detected(detected), .stat_agc(stat_agc), .stat_psy(stat_psy),
   .agc_live(agc_live), .psy_live(psy_live)
);

// File: tb/test_vbi_pulse_scan.sv
module test_vbi_pulse_scan;
   localparam int SMP_W = 10, LINE_W = 10, POS_W = 12, WID_W = 4, CNT_W = 6, FLD_W = 3;
   localparam int BASE = 256;
   localparam int CMAX = 63;

   typedef struct packed {
      logic [CNT_W-1:0] agc;
      logic [CNT_W-1:0] psy;
      logic             det;
   } item_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic smp_valid = 1'b0, field_done = 1'b0;
   logic [SMP_W-1:0] smp_data = BASE;
   logic [LINE_W-1:0] line_num = '0;
   logic [POS_W-1:0] line_pos = '0;
   logic [LINE_W-1:0] cfg_start_line = 10'd6, cfg_stop_line = 10'd15;
   logic [SMP_W-1:0] cfg_hi_thr = 10'd700, cfg_lo_thr = 10'd100;
   logic [WID_W-1:0] cfg_min_width = 4'd4;
   logic [POS_W-1:0] cfg_sync_guard = 12'd40;
   logic [CNT_W-1:0] cfg_agc_min = 6'd2, cfg_psy_min = 6'd2;
   logic [FLD_W-1:0] cfg_fields = 3'd2;
   logic [CNT_W-1:0] stat_agc, stat_psy;
   logic stat_valid, detected;

   int checks = 0, failures = 0;
   int exp_agc = 0, exp_psy = 0;
   int streak_m = 0;
   bit det_m = 0;
   item_t sb_q[$];
   item_t last_item = '0;
   bit done = 0;

   always #4 clk = ~clk;

   vbi_pulse_scan #(.SMP_W(SMP_W), .LINE_W(LINE_W), .POS_W(POS_W), .WID_W(WID_W),
                    .CNT_W(CNT_W), .FLD_W(FLD_W)) i_vbi_pulse_scan (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .line_num(line_num), .line_pos(line_pos), .field_done(field_done),
      .cfg_start_line(cfg_start_line), .cfg_stop_line(cfg_stop_line),
      .cfg_hi_thr(cfg_hi_thr), .cfg_lo_thr(cfg_lo_thr), .cfg_min_width(cfg_min_width),
      .cfg_sync_guard(cfg_sync_guard), .cfg_agc_min(cfg_agc_min), .cfg_psy_min(cfg_psy_min),
      .cfg_fields(cfg_fields), .stat_agc(stat_agc), .stat_psy(stat_psy),
      .stat_valid(stat_valid), .detected(detected)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit in_win(int l);
      return (cfg_stop_line >= cfg_start_line) && (l >= cfg_start_line) && (l <= cfg_stop_line);
   endfunction

   function automatic int eff_min();
      return (cfg_min_width == 0) ? 1 : int'(cfg_min_width);
   endfunction

   task automatic put(bit v, int l, int p, int d);
      smp_valid = v; line_num = LINE_W'(l); line_pos = POS_W'(p); smp_data = SMP_W'(d);
      @(negedge clk);
   endtask

   // Driver: one pulse of len samples then a blank sample; model per R2/R3/R4
   task automatic pulse(int l, int p0, int val, int len);
      int g;
      int eff_len;
      for (int i = 0; i < len; i++) put(1, l, p0 + i, val);
      put(1, l, p0 + len, BASE);
      if (in_win(l)) begin
         if (val > cfg_hi_thr && len >= eff_min()) exp_agc = (exp_agc < CMAX) ? exp_agc + 1 : CMAX;
         if (val < cfg_lo_thr) begin
            g = int'(cfg_sync_guard);
            eff_len = (p0 >= g) ? len : ((p0 + len > g) ? p0 + len - g : 0);
            if (eff_len >= eff_min()) exp_psy = (exp_psy < CMAX) ? exp_psy + 1 : CMAX;
         end
      end
   endtask

   // Field boundary: model R7/R8 and push expected item
   task automatic end_field();
      bit qual;
      int need;
      item_t it;
      qual = (exp_agc >= cfg_agc_min) && (exp_psy >= cfg_psy_min);
      need = (cfg_fields == 0) ? 1 : int'(cfg_fields);
      if (qual == det_m) streak_m = 0;
      else if (streak_m + 1 >= need) begin streak_m = 0; det_m = qual; end
      else streak_m++;
      it.agc = CNT_W'(exp_agc); it.psy = CNT_W'(exp_psy); it.det = det_m;
      sb_q.push_back(it);
      exp_agc = 0; exp_psy = 0;
      smp_valid = 0; field_done = 1;
      @(negedge clk);
      field_done = 0;
      @(negedge clk);
   endtask

   task automatic qual_field(int n_agc, int n_psy);
      for (int k = 0; k < n_agc; k++) pulse(9, 100 + 10 * k, 900, 5);
      for (int k = 0; k < n_psy; k++) pulse(10, 200 + 10 * k, 50, 4);
   endtask

   // Monitor: pops expected items when the status word updates (R5, R7, R8)
   always @(negedge clk) begin
      if (rst_n && stat_valid) begin
         if (sb_q.size() == 0) begin
            check("R5 unexpected stat_valid", 1, 0);
         end else begin
            item_t e;
            e = sb_q.pop_front();
            check("R5 stat_agc", int'(stat_agc), int'(e.agc));
            check("R5 stat_psy", int'(stat_psy), int'(e.psy));
            check("R7/R8 detected", int'(detected), int'(e.det));
            last_item = e;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 stat_agc", int'(stat_agc), 0);
      check("R1 stat_psy", int'(stat_psy), 0);
      check("R1 stat_valid", int'(stat_valid), 0);
      check("R1 detected", int'(detected), 0);

      // Field 1: window edges, short runs, guard (R2 R3 R4)
      pulse(8, 100, 900, 4);     // counted
      pulse(8, 120, 900, 3);     // too short
      pulse(8, 200, 50, 5);      // counted
      pulse(3, 100, 900, 10);    // outside window
      pulse(15, 100, 900, 6);    // stop line inclusive
      pulse(16, 100, 900, 6);    // outside window
      pulse(6, 0, 50, 10);       // before guard, R4
      pulse(6, 35, 50, 8);       // only 3 samples past guard
      // R9: status unchanged mid-field
      check("R9 stat_agc mid-field", int'(stat_agc), 0);
      end_field();               // 2/1 not qualifying

      qual_field(3, 2); end_field();   // streak 1
      qual_field(3, 2); end_field();   // R7 detected rises
      qual_field(1, 0); end_field();   // non-qual, still set
      qual_field(2, 2); end_field();   // R8 restarts clear streak
      qual_field(0, 2); end_field();
      check("R9 detected held between fields", int'(detected), 1);
      qual_field(2, 0); end_field();   // R8 detected falls

      // R6 saturation
      for (int k = 0; k < 70; k++) pulse(10, 50 + 5 * k, 900, 4);
      end_field();

      // R2 disabled window
      cfg_stop_line = 10'd5;
      for (int l = 0; l < 20; l++) pulse(l, 100, 900, 6);
      for (int l = 0; l < 20; l++) pulse(l, 100, 50, 6);
      end_field();
      cfg_stop_line = 10'd15;

      // R3 width 0 acts as 1
      cfg_min_width = 4'd0;
      pulse(7, 100, 900, 1);
      pulse(7, 110, 50, 1);
      end_field();
      cfg_min_width = 4'd4;

      // R10 invalid cycles hold a run: 2 + gap + 2 = 4 samples, counted once
      put(1, 11, 300, 900); put(1, 11, 301, 900);
      put(0, 11, 302, BASE); put(0, 11, 303, BASE);
      put(1, 11, 304, 900); put(1, 11, 305, 900);
      put(1, 11, 306, BASE);
      exp_agc++;
      // R10 failing sample breaks the run: 2 + blank + 2, not counted
      put(1, 11, 400, 900); put(1, 11, 401, 900); put(1, 11, 402, BASE);
      put(1, 11, 403, 900); put(1, 11, 404, 900); put(1, 11, 405, BASE);
      end_field();

      repeat (3) @(negedge clk);
      check("R5 all status words seen", sb_q.size(), 0);
      check("R9 stat stable after last field", int'(stat_agc), int'(last_item.agc));
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule